// File: doc/BRIEF.md
# Transmit Slip Buffer with Settable Latency

This block takes bytes from a 32-channel backplane and sends them out as a bit-serial 24-timeslot DS1 frame of 193 bits. Each clock cycle is one DS1 bit period. A backplane write carries a channel index and a data byte. A fixed mapping drops every fourth channel and stores the other 24 as timeslots in one of two frame-sized banks. The read side makes its own frame. It shifts each timeslot out MSB first and marks the framing-bit position with a one-cycle sync pulse.

The latency through the buffer is set by a host write to an 8-bit delay register. A non-zero write arms a single realignment. The next backplane write of the channel that carries timeslot 1 starts a countdown. When the countdown ends, the generated frame restarts at its framing bit, so the timeslot-1 byte is loaded exactly the programmed number of bit periods after it was written. After that the frame runs freely until the next non-zero host write.

Top module: `tx_elastic_buf`

## Requirements
- R1: While synchronous reset is held, the frame position is at the framing bit: `tx_fsync` is 1, `tx_data` is 0 and `host_rdata` is 0. Both buffer banks hold zero bytes.
- R2: The generated frame is 193 bit periods long. `tx_fsync` is high for exactly the one framing-bit cycle, and `tx_data` is 0 in that cycle. Without a realignment, consecutive sync pulses are 193 cycles apart.
- R3: Backplane channel c with c mod 4 not equal to 0 feeds timeslot c - floor(c/4). Channel 1 carries timeslot 1 and channel 31 carries timeslot 24. Channels 0, 4, 8 ... 28 are discarded. Timeslot k occupies frame bit positions 8k-7 to 8k and is sent MSB first.
- R4: After a non-zero host write of D, take Tw as the first later clock edge that accepts a channel-1 write. The framing bit then appears in the cycle after edge Tw+D-1. The byte written at Tw is loaded at edge Tw+D and sent in the following 8 cycles. This gives a write-to-read spacing of D bit periods, which is always less than one frame.
- R5: A host value from 193 to 255 is stored as 192. `host_rdata` returns the value last stored, one cycle after the write.
- R6: A host write of zero is ignored. `host_rdata` keeps its value, and the frame phase does not change.
- R7: Each non-zero host write produces one realignment only. Later channel-1 writes and shifts in backplane frame timing leave the 193-cycle sync period unchanged.
- R8: Two banks of 24 bytes are kept. A backplane frame marker switches the write bank, and that switch applies to a write in the same cycle. The read bank switches at every frame end. A realignment selects the bank that holds the timeslot-1 byte that triggered it. If a host write arrives in the same cycle as a pending channel-1 write or the last countdown cycle, the host write wins and rearms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one DS1 bit period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_fsync | input | 1 | Backplane frame marker, switches the write bank |
| wr_en | input | 1 | Backplane byte write strobe |
| wr_chan | input | 5 | Backplane channel index 0..31 |
| wr_data | input | 8 | Backplane byte |
| host_we | input | 1 | Host write strobe for the delay register |
| host_wdata | input | 8 | Requested delay in bit periods |
| host_rdata | output | 8 | Stored (clamped) delay value |
| tx_data | output | 1 | Serial DS1 data, 0 at the framing bit |
| tx_fsync | output | 1 | High during the framing-bit cycle |

## Verification
The assertions assume that each cycle is one DS1 bit period, that host writes are single-cycle strobes, and that the realignment pulse comes only from the countdown after an armed channel-1 write. Because of that, the sync pulse is single-cycle everywhere except at a forced restart, and the gap between pulses can never exceed 193 cycles. The stimulus writes backplane channels at a fixed six-cycle spacing inside frames that are normally 193 cycles long, with distinct byte values per frame and channel. It puts host writes at arbitrary backplane offsets, and it stretches one backplane frame on purpose to test that realignment fires only once.

// File: rtl/txeb_pkg.sv
// Shared definitions for the transmit slip buffer.
// Assumes an 8-bit byte lane on both the backplane and DS1 sides.
package txeb_pkg;

    localparam int BYTE_W = 8;

    // Realignment controller states
    typedef enum logic [1:0] {
        AL_IDLE  = 2'd0,
        AL_ARMED = 2'd1,
        AL_COUNT = 2'd2
    } align_st_e;

endpackage

// File: rtl/txeb_chan_map.sv
// Backplane side: tracks the write bank and maps channel indices to
// timeslot slots. Assumes one channel out of every SKIP is unused.
module txeb_chan_map
    import txeb_pkg::*;
#(
    parameter int BP_CHANS = 32,
    parameter int SLOTS    = 24,
    parameter int SKIP     = 4,
    localparam int CH_W    = $clog2(BP_CHANS),
    localparam int SL_W    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bp_fsync,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              st_we,
    output logic              st_bank,
    output logic [SL_W-1:0]   st_slot,
    output logic [BYTE_W-1:0] st_data,
    output logic              ts1_hit
);

    logic wr_bank;
    logic eff_bank;
    logic chan_ok;
    int   idx;

    // Decode channel into slot index and acceptance
    always_comb begin
        eff_bank = wr_bank ^ bp_fsync;
        idx      = int'(wr_chan) - int'(wr_chan) / SKIP - 1;
        chan_ok  = ((int'(wr_chan) % SKIP) != 0) && (idx < SLOTS) && (idx >= 0);
        st_we    = wr_en && chan_ok;
        st_bank  = eff_bank;
        st_slot  = chan_ok ? SL_W'(idx) : '0;
        st_data  = wr_data;
        ts1_hit  = st_we && (idx == 0);
    end

    // Write bank flips on each backplane frame marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank <= 1'b0;
        end else begin
            wr_bank <= eff_bank;
        end
    end

endmodule

// File: rtl/txeb_store.sv
// Two-bank byte store, one bank per frame. Write is registered; read is
// combinational so a byte written at an edge is readable after it.
module txeb_store
    import txeb_pkg::*;
#(
    parameter int SLOTS  = 24,
    localparam int SL_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wbank,
    input  logic [SL_W-1:0]   wslot,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rbank,
    input  logic [SL_W-1:0]   rslot,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [2][SLOTS];

    // Clear on reset, otherwise store the mapped byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    mem[b][s] <= '0;
                end
            end
        end else if (we) begin
            mem[wbank][wslot] <= wdata;
        end
    end

    // Read port used by the framer when loading a timeslot
    always_comb begin
        rdata = mem[rbank][rslot];
    end

endmodule

// File: rtl/txeb_align.sv
// Delay register and one-shot realignment control. A non-zero host write
// arms; the next timeslot-1 write starts a countdown of D-1 edges, after
// which a single realign pulse restarts the generated frame.
module txeb_align
    import txeb_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int DLY_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [DLY_W-1:0] host_wdata,
    input  logic             ts1_hit,
    input  logic             hit_bank,
    output logic [DLY_W-1:0] dly_q,
    output logic             realign,
    output logic             realign_bank
);

    localparam int MAXD = FRAME_BITS - 1;

    align_st_e        state;
    logic [DLY_W-1:0] cnt;
    logic             held_bank;
    logic             host_nz;
    logic [DLY_W-1:0] clamped;
    logic             fire_now;
    logic             fire_cnt;

    // Host write qualification, clamping and fire conditions
    always_comb begin
        host_nz      = host_we && (host_wdata != '0);
        clamped      = (int'(host_wdata) > MAXD) ? DLY_W'(MAXD) : host_wdata;
        fire_now     = (state == AL_ARMED) && ts1_hit && (dly_q == DLY_W'(1));
        fire_cnt     = (state == AL_COUNT) && (cnt == DLY_W'(1));
        realign      = !host_nz && (fire_now || fire_cnt);
        realign_bank = (state == AL_ARMED) ? hit_bank : held_bank;
    end

    // Register, arming and countdown sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= AL_IDLE;
            dly_q     <= '0;
            cnt       <= '0;
            held_bank <= 1'b0;
        end else if (host_nz) begin
            dly_q <= clamped;
            state <= AL_ARMED;
        end else begin
            unique case (state)
                AL_ARMED: begin
                    if (ts1_hit) begin
                        held_bank <= hit_bank;
                        if (dly_q == DLY_W'(1)) begin
                            state <= AL_IDLE;
                        end else begin
                            cnt   <= dly_q - DLY_W'(1);
                            state <= AL_COUNT;
                        end
                    end
                end
                AL_COUNT: begin
                    if (cnt == DLY_W'(1)) begin
                        state <= AL_IDLE;
                    end else begin
                        cnt <= cnt - DLY_W'(1);
                    end
                end
                default: state <= AL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txeb_framer.sv
// Generated DS1 frame: bit counter, read bank, timeslot shift register.
// Position 0 is the framing bit (output 0, sync high); slot k starts at
// position 1 + k*BYTE_W. A realign pulse forces position 0 immediately.
module txeb_framer
    import txeb_pkg::*;
#(
    parameter int SLOTS      = 24,
    parameter int FRAME_BITS = 193,
    localparam int SL_W      = $clog2(SLOTS),
    localparam int BC_W      = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              realign,
    input  logic              realign_bank,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_bank,
    output logic [SL_W-1:0]   rd_slot,
    output logic              tx_data,
    output logic              tx_fsync
);

    localparam int LAST = FRAME_BITS - 1;

    logic [BC_W-1:0]   bit_cnt;
    logic [BC_W-1:0]   next_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              load;
    int                nm1;

    // Next position and timeslot load decision
    always_comb begin
        next_cnt = (bit_cnt == BC_W'(LAST)) ? '0 : bit_cnt + BC_W'(1);
        nm1      = int'(next_cnt) - 1;
        load     = !realign && (next_cnt != '0) && ((nm1 % BYTE_W) == 0);
        rd_slot  = load ? SL_W'(nm1 / BYTE_W) : '0;
    end

    // Frame position, read bank and shift register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rd_bank <= 1'b0;
            shreg   <= '0;
        end else if (realign) begin
            bit_cnt <= '0;
            rd_bank <= realign_bank;
            shreg   <= shreg << 1;
        end else begin
            bit_cnt <= next_cnt;
            if (bit_cnt == BC_W'(LAST)) begin
                rd_bank <= ~rd_bank;
            end
            shreg <= load ? rd_data : (shreg << 1);
        end
    end

    // Serial outputs
    always_comb begin
        tx_fsync = (bit_cnt == '0);
        tx_data  = (bit_cnt == '0) ? 1'b0 : shreg[BYTE_W-1];
    end

endmodule

// File: rtl/tx_elastic_buf.sv
// Top of the transmit slip buffer. Single clock at the DS1 bit rate.
// Assumes backplane writes arrive at roughly one frame per 193 cycles.
module tx_elastic_buf
    import txeb_pkg::*;
#(
    parameter int BP_CHANS   = 32,
    parameter int SLOTS      = 24,
    parameter int SKIP       = 4,
    parameter int FRAME_BITS = 193,
    parameter int DLY_W      = 8,
    localparam int CH_W      = $clog2(BP_CHANS),
    localparam int SL_W      = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bp_fsync,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              host_we,
    input  logic [DLY_W-1:0]  host_wdata,
    output logic [DLY_W-1:0]  host_rdata,
    output logic              tx_data,
    output logic              tx_fsync
);

    logic              st_we;
    logic              st_bank;
    logic [SL_W-1:0]   st_slot;
    logic [BYTE_W-1:0] st_data;
    logic              ts1_hit;
    logic              realign;
    logic              realign_bank;
    logic              rd_bank;
    logic [SL_W-1:0]   rd_slot;
    logic [BYTE_W-1:0] rd_data;

    txeb_chan_map #(.BP_CHANS(BP_CHANS), .SLOTS(SLOTS), .SKIP(SKIP)) u_map (
        .clk(clk), .rst_n(rst_n), .bp_fsync(bp_fsync), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_data(wr_data), .st_we(st_we), .st_bank(st_bank),
        .st_slot(st_slot), .st_data(st_data), .ts1_hit(ts1_hit)
    );

    txeb_store #(.SLOTS(SLOTS)) u_store (
        .clk(clk), .rst_n(rst_n), .we(st_we), .wbank(st_bank), .wslot(st_slot),
        .wdata(st_data), .rbank(rd_bank), .rslot(rd_slot), .rdata(rd_data)
    );

    txeb_align #(.FRAME_BITS(FRAME_BITS), .DLY_W(DLY_W)) u_align (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .ts1_hit(ts1_hit), .hit_bank(st_bank), .dly_q(host_rdata),
        .realign(realign), .realign_bank(realign_bank)
    );

    txeb_framer #(.SLOTS(SLOTS), .FRAME_BITS(FRAME_BITS)) u_framer (
        .clk(clk), .rst_n(rst_n), .realign(realign), .realign_bank(realign_bank),
        .rd_data(rd_data), .rd_bank(rd_bank), .rd_slot(rd_slot),
        .tx_data(tx_data), .tx_fsync(tx_fsync)
    );

endmodule

// File: rtl/txeb_checker.sv
// Assertion checker bound to tx_elastic_buf. Observes ports plus the
// realign pulse and store write enable driven by separate submodules.
module txeb_checker #(
    parameter int FRAME_BITS = 193,
    parameter int SKIP       = 4,
    parameter int CH_W       = 5,
    parameter int DLY_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CH_W-1:0]  wr_chan,
    input logic             host_we,
    input logic [DLY_W-1:0] host_wdata,
    input logic [DLY_W-1:0] host_rdata,
    input logic             tx_fsync,
    input logic             realign,
    input logic             st_we
);

    logic [15:0] gap;

    // Cycles elapsed since the last sync pulse (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n || tx_fsync) begin
            gap <= '0;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 16'd1;
        end
    end

    // R2: never more than one frame between sync pulses
    a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gap) <= FRAME_BITS - 1);

    // R2: sync is a single-cycle pulse unless a restart is forced
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fsync && !realign) |=> !tx_fsync);

    // R4: a realign pulse puts the next cycle on the framing bit
    a_r4_realign_sync: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> tx_fsync);

    // R4: a non-zero write leaves a non-zero stored delay
    a_r4_nonzero_store: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_wdata != '0) |=> (host_rdata != '0));

    // R5: the stored delay never reaches one frame
    a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        int'(host_rdata) <= FRAME_BITS - 1);

    // R6: zero writes leave the stored delay untouched
    a_r6_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_wdata == '0) |=> $stable(host_rdata));

    // R3: unused channels never reach the store
    a_r3_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_chan) % SKIP == 0)) |-> !st_we);

    // R3: used channels always reach the store
    a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_chan) % SKIP != 0)) |-> st_we);

endmodule

bind tx_elastic_buf txeb_checker #(
    .FRAME_BITS(FRAME_BITS), .SKIP(SKIP), .CH_W(CH_W), .DLY_W(DLY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_fsync(tx_fsync), .realign(realign), .st_we(st_we)
);

// File: tb/sim_tx_elastic_buf.sv
module sim_tx_elastic_buf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bp_fsync = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_chan = '0;
    logic [7:0] wr_data = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_data;
    logic       tx_fsync;

    always #2 clk = ~clk;

    tx_elastic_buf u0 (
        .clk(clk), .rst_n(rst_n), .bp_fsync(bp_fsync), .wr_en(wr_en),
        .wr_chan(wr_chan), .wr_data(wr_data), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_data(tx_data), .tx_fsync(tx_fsync)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int ecount = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, ecount);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_mem [2][24];
    int m_phase, m_rbank, m_wbank, m_sh, m_d, m_state, m_cd, m_cbank;
    // Directed monitor state
    int mon_d = 0, mon_exp = -1, mon_byte = 0, mon_acc = 0;
    bit mon_wait = 0;

    always @(posedge clk) begin
        ecount++;
        if (!rst_n) begin
            foreach (m_mem[b, s]) m_mem[b][s] = 0;
            m_phase = 0; m_rbank = 0; m_wbank = 0; m_sh = 0;
            m_d = 0; m_state = 0; m_cd = 0; m_cbank = 0;
            mon_wait = 0;
        end else begin
            int eff;
            int nxt;
            bit fire;
            fire = 0;
            eff = m_wbank ^ int'(bp_fsync);
            if (host_we && host_wdata != 0) begin
                m_d = (host_wdata > 192) ? 192 : int'(host_wdata);
                m_state = 1;
                mon_d = m_d; mon_wait = 1;
            end else begin
                if (m_state == 1 && wr_en && wr_chan == 1) begin
                    m_cbank = eff;
                    if (m_d == 1) begin fire = 1; m_state = 0; end
                    else begin m_cd = m_d - 1; m_state = 2; end
                end else if (m_state == 2) begin
                    if (m_cd == 1) begin fire = 1; m_state = 0; end
                    else m_cd--;
                end
                if (mon_wait && wr_en && wr_chan == 1) begin
                    mon_wait = 0;
                    mon_exp = ecount + mon_d - 1;
                    mon_byte = int'(wr_data);
                end
            end
            if (fire) begin
                m_phase = 0;
                m_rbank = m_cbank;
            end else begin
                nxt = (m_phase == 192) ? 0 : m_phase + 1;
                if (m_phase == 192) m_rbank ^= 1;
                if (nxt != 0 && (nxt - 1) % 8 == 0) m_sh = m_mem[m_rbank][(nxt - 1) / 8];
                else m_sh = (m_sh << 1) & 255;
                m_phase = nxt;
            end
            m_wbank = eff;
            if (wr_en && (int'(wr_chan) % 4) != 0)
                m_mem[eff][int'(wr_chan) - int'(wr_chan) / 4 - 1] = int'(wr_data);
        end
    end

    // Compare against the model and run directed monitors, away from the edge
    bit free_win = 0;
    int last_fs = -1;
    int exp_rd = 0;

    always @(negedge clk) begin
        if (ecount > 0 && !done) begin
            int exp_d;
            exp_d = (m_phase == 0) ? 0 : ((m_sh >> 7) & 1);
            chk(tx_fsync == (m_phase == 0), "R2 R8 sync stream", int'(tx_fsync), int'(m_phase == 0));
            chk(tx_data == exp_d[0], "R3 R8 data stream", int'(tx_data), exp_d);
            exp_rd = (m_state == 0 && m_d == 0) ? 0 : m_d;
            chk(int'(host_rdata) == exp_rd, "R5 readback", int'(host_rdata), exp_rd);
            if (ecount == mon_exp) begin
                chk(tx_fsync == 1'b1, "R4 framing bit at write+D-1", int'(tx_fsync), 1);
                mon_acc = 0;
            end
            if (mon_exp >= 0 && ecount > mon_exp && ecount <= mon_exp + 8) begin
                mon_acc = (mon_acc << 1) | int'(tx_data);
                if (ecount == mon_exp + 8)
                    chk(mon_acc == mon_byte, "R4 timeslot 1 byte", mon_acc, mon_byte);
            end
            if (mon_exp >= 0 && ecount == mon_exp + 193)
                chk(tx_fsync == 1'b1, "R7 frame after realign", int'(tx_fsync), 1);
            if (ecount > 6 && tx_fsync) begin
                if (free_win && last_fs >= 0)
                    chk(ecount - last_fs == 193, "R2 R7 sync period", ecount - last_fs, 193);
                last_fs = ecount;
            end
        end
    end

    // Backplane generator: channel c written at offset 6*c of each frame
    int bp_len = 193;
    int bp_off = 0;
    int bp_frame = 0;

    task automatic step(input bit hw, input int hv);
        @(negedge clk);
        bp_fsync = (bp_off == 0);
        wr_en = 1'b0; wr_chan = '0; wr_data = '0;
        if (bp_off % 6 == 0 && bp_off / 6 < 32) begin
            wr_en = 1'b1;
            wr_chan = 5'(bp_off / 6);
            wr_data = 8'((bp_frame * 37 + (bp_off / 6) * 11 + 5) & 255);
        end
        host_we = hw;
        host_wdata = 8'(hv);
        bp_off++;
        if (bp_off >= bp_len) begin
            bp_off = 0;
            bp_frame++;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0);
    endtask

    task automatic open_window();
        last_fs = -1;
        free_win = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_fsync == 1'b1 && tx_data == 1'b0, "R1 reset frame position", int'(tx_fsync), 1);
        chk(host_rdata == 8'd0, "R1 reset readback", int'(host_rdata), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        open_window();
        run(600);
        // R4: ordinary delay
        free_win = 0;
        step(1'b1, 50);
        run(450);
        open_window();
        run(400);
        // R6: zero write must not disturb anything
        step(1'b1, 0);
        run(2);
        chk(host_rdata == 8'd50, "R6 zero write ignored", int'(host_rdata), 50);
        run(400);
        // R5: clamp to 192
        free_win = 0;
        step(1'b1, 200);
        run(2);
        chk(host_rdata == 8'd192, "R5 clamp", int'(host_rdata), 192);
        run(450);
        open_window();
        run(400);
        // R4: minimum delay of one bit period
        free_win = 0;
        step(1'b1, 1);
        run(450);
        open_window();
        run(200);
        // R7: stretch one backplane frame; generated frame must not move
        bp_len = 205;
        run(250);
        bp_len = 193;
        run(800);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", ecount, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule